// File: doc/BRIEF.md
# Tester Pin Drive Format Generator

One instance serves one channel of a vector-driven digital tester. It runs on a fast phase clock. A one-cycle `vec_start` pulse marks the start of each vector period. At that pulse the block captures the data bit, the output-vector flag, the format code and two phase times. For the rest of the period it produces a drive level and a driver enable from them.

A phase counter starts at zero in the first cycle of the period and counts phase-clock cycles. The counter is compared against the assert time and the return time, which splits the period into three windows: before assert, the active window, and from return onward. The chosen format maps the data bit and the current window onto the driver. The formats cover non-return drive, return to low, high or high impedance, complement return, surround, three constant forces, and two phase-following clock modes.

A latched over-current fault overrides every format and holds the driver in high impedance. It stays set until a clear request arrives in a cycle that has no new over-current event. Whenever the driver is disabled, the level output is held low.

Top module: `pfg_pin_formatter`

## Requirements
- R1: Format code 0 (non-return) enables the driver for the whole period and drives the data bit throughout.
- R2: Format codes 1 and 2 drive the data bit while the phase count is below the return time, then drive low (code 1) or high (code 2) for the rest of the period.
- R3: Format code 3 drives the data bit while the phase count is below the return time, then disables the driver.
- R4: Format code 4 drives the data bit before the return time and its complement from the return time on.
- R5: Format code 5 disables the driver while the count is below the assert time, drives the data bit in the active window, and disables the driver from the return time on.
- R6: Format codes 6, 7 and 8 give constant low, constant high and a disabled driver, whatever the data bit.
- R7: Format code 9 drives high inside the active window and low outside it. Format code 10 drives the inverse of code 9.
- R8: A period captured with the output-vector flag clear keeps the driver disabled for the whole period, in every format.
- R9: An over-current event sets the fault output one cycle later. The fault stays set until a clear request is seen in a cycle with no event. An event in the same cycle as a clear keeps the fault set.
- R10: While the fault is set, the driver is disabled.
- R11: The phase count is 0 in the cycle after the `vec_start` edge and rises by one per cycle, saturating at its maximum value. The active window is count ≥ assert and count < return.
- R12: Format, data, output flag and phase times are sampled only at `vec_start`. Input changes during a period have no effect until the next period.
- R13: Whenever the driver is disabled, the level output is 0. Unused format codes 11 to 15 behave as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_start | input | 1 | One-cycle pulse starting a vector period |
| vec_data | input | 1 | Data bit of the vector |
| vec_is_out | input | 1 | Vector is an output vector |
| fmt_sel | input | 4 | Format code |
| t_assert | input | TW (6) | Assert time in phase-clock cycles |
| t_return | input | TW (6) | Return time in phase-clock cycles |
| oc_event | input | 1 | Over-current detected |
| fault_clr | input | 1 | Clear request for the fault latch |
| drv_level | output | 1 | Drive level |
| drv_en | output | 1 | Driver enable (0 = high impedance) |
| fault | output | 1 | Latched over-current fault |

## Verification
The assertions check the following on every cycle:
- the captured configuration holds steady between period starts;
- the phase counter restarts at zero and saturates;
- the fault latch sets, holds and clears as specified;
- an over-current event or an input vector always leaves the driver disabled in the next cycle.

Only the bench's directed scenarios can show that each format places its transitions at the right phase counts. The same holds for the exact data-to-level mapping, the effect of unused format codes, and the fact that a mid-period input change stays invisible until the next start.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    typedef enum logic [3:0] {
        FMT_NR    = 4'd0,
        FMT_RZ    = 4'd1,
        FMT_RO    = 4'd2,
        FMT_RHZ   = 4'd3,
        FMT_RC    = 4'd4,
        FMT_SURR  = 4'd5,
        FMT_F0    = 4'd6,
        FMT_F1    = 4'd7,
        FMT_FOFF  = 4'd8,
        FMT_FPH   = 4'd9,
        FMT_FIPH  = 4'd10
    } fmt_e;

    typedef struct packed {
        logic [3:0] fmt;
        logic       data;
        logic       is_out;
    } per_cfg_t;

    typedef struct packed {
        logic pre;   // count below assert time
        logic post;  // count at or beyond return time
    } phase_t;

    typedef struct packed {
        logic en;
        logic lvl;
    } drv_t;

    // Map format, data bit and phase window onto the driver.
    function automatic drv_t shape(logic [3:0] f, logic d, phase_t p);
        drv_t r;
        logic act;
        act   = !p.pre && !p.post;
        r.en  = 1'b1;
        r.lvl = d;
        case (f)
            FMT_RZ:   if (p.post) r.lvl = 1'b0;
            FMT_RO:   if (p.post) r.lvl = 1'b1;
            FMT_RHZ:  if (p.post) r.en  = 1'b0;
            FMT_RC:   if (p.post) r.lvl = !d;
            FMT_SURR: r.en  = act;
            FMT_F0:   r.lvl = 1'b0;
            FMT_F1:   r.lvl = 1'b1;
            FMT_FOFF: r.en  = 1'b0;
            FMT_FPH:  r.lvl = act;
            FMT_FIPH: r.lvl = !act;
            default:  ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pfg_cfg_latch.sv
module pfg_cfg_latch
    import pfg_pkg::*;
#(
    parameter int TW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vec_start,
    input  logic [3:0]        fmt_in,
    input  logic              data_in,
    input  logic              out_in,
    input  logic [TW-1:0]     ta_in,
    input  logic [TW-1:0]     tr_in,
    output per_cfg_t          cfg,
    output logic [TW-1:0]     ta_q,
    output logic [TW-1:0]     tr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '{fmt: FMT_NR, data: 1'b0, is_out: 1'b0};
            ta_q <= '0;
            tr_q <= '0;
        end else if (vec_start) begin
            cfg  <= '{fmt: fmt_in, data: data_in, is_out: out_in};
            ta_q <= ta_in;
            tr_q <= tr_in;
        end
    end

    assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !vec_start |=> ($stable(cfg) && $stable(ta_q) && $stable(tr_q)));

endmodule

// File: rtl/pfg_phase_ctr.sv
module pfg_phase_ctr
    import pfg_pkg::*;
#(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vec_start,
    input  logic [TW-1:0] ta,
    input  logic [TW-1:0] tr,
    output phase_t        ph
);

    localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                 cnt <= '0;
        else if (vec_start)      cnt <= '0;
        else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    always_comb begin
        ph.pre  = (cnt < ta);
        ph.post = (cnt >= tr);
    end

    assert_cnt_restart_R11: assert property (@(posedge clk) disable iff (rst)
        vec_start |=> (cnt == '0));

    assert_cnt_saturate_R11: assert property (@(posedge clk) disable iff (rst)
        (!vec_start && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

endmodule

// File: rtl/pfg_fault.sv
module pfg_fault (
    input  logic clk,
    input  logic rst,
    input  logic oc_event,
    input  logic clr,
    output logic fault
);

    always_ff @(posedge clk) begin
        if (rst)           fault <= 1'b0;
        else if (oc_event) fault <= 1'b1;
        else if (clr)      fault <= 1'b0;
    end

    assert_fault_set_R9: assert property (@(posedge clk) disable iff (rst)
        oc_event |=> fault);

    assert_fault_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (fault && !clr) |=> fault);

    assert_fault_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (clr && !oc_event) |=> !fault);

endmodule

// File: rtl/pfg_pin_formatter.sv
module pfg_pin_formatter
    import pfg_pkg::*;
#(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vec_start,
    input  logic          vec_data,
    input  logic          vec_is_out,
    input  logic [3:0]    fmt_sel,
    input  logic [TW-1:0] t_assert,
    input  logic [TW-1:0] t_return,
    input  logic          oc_event,
    input  logic          fault_clr,
    output logic          drv_level,
    output logic          drv_en,
    output logic          fault
);

    per_cfg_t      cfg;
    logic [TW-1:0] ta_q;
    logic [TW-1:0] tr_q;
    phase_t        ph;
    drv_t          sh;

    pfg_cfg_latch #(.TW(TW)) u_cfg (
        .clk(clk), .rst(rst), .vec_start(vec_start),
        .fmt_in(fmt_sel), .data_in(vec_data), .out_in(vec_is_out),
        .ta_in(t_assert), .tr_in(t_return),
        .cfg(cfg), .ta_q(ta_q), .tr_q(tr_q)
    );

    pfg_phase_ctr #(.TW(TW)) u_ctr (
        .clk(clk), .rst(rst), .vec_start(vec_start),
        .ta(ta_q), .tr(tr_q), .ph(ph)
    );

    pfg_fault u_flt (
        .clk(clk), .rst(rst), .oc_event(oc_event), .clr(fault_clr),
        .fault(fault)
    );

    always_comb begin
        sh        = shape(cfg.fmt, cfg.data, ph);
        drv_en    = sh.en && cfg.is_out && !fault;
        drv_level = drv_en && sh.lvl;
    end

    assert_input_vec_hiz_R8: assert property (@(posedge clk) disable iff (rst)
        (vec_start && !vec_is_out) |=> !drv_en);

    assert_event_hiz_R10: assert property (@(posedge clk) disable iff (rst)
        oc_event |=> !drv_en);

    assert_off_level_low_R13: assert property (@(posedge clk) disable iff (rst)
        (vec_start && fmt_sel == FMT_FOFF) |=> (!drv_en && !drv_level));

endmodule

// File: tb/tb_pfg_pin_formatter.sv
module tb_pfg_pin_formatter;

    localparam int CLK_PERIOD = 10;
    localparam int TW = 6;
    localparam int CMAX = (1 << TW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          vec_start = 1'b0;
    logic          vec_data = 1'b0;
    logic          vec_is_out = 1'b0;
    logic [3:0]    fmt_sel = 4'd0;
    logic [TW-1:0] t_assert = '0;
    logic [TW-1:0] t_return = '0;
    logic          oc_event = 1'b0;
    logic          fault_clr = 1'b0;
    logic          drv_level;
    logic          drv_en;
    logic          fault;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    pfg_pin_formatter #(.TW(TW)) dut (
        .clk(clk), .rst(rst), .vec_start(vec_start), .vec_data(vec_data),
        .vec_is_out(vec_is_out), .fmt_sel(fmt_sel), .t_assert(t_assert),
        .t_return(t_return), .oc_event(oc_event), .fault_clr(fault_clr),
        .drv_level(drv_level), .drv_en(drv_en), .fault(fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected {en, level} from the requirement text.
    function automatic logic [1:0] model(int f, bit d, bit o, int ta, int tr,
                                         int k, bit flt);
        int  c;
        bit  pre, post, act, en, lv;
        c    = (k > CMAX) ? CMAX : k;
        pre  = (c < ta);
        post = (c >= tr);
        act  = !pre && !post;
        en   = 1'b1;
        lv   = d;
        case (f)
            1:  if (post) lv = 1'b0;
            2:  if (post) lv = 1'b1;
            3:  if (post) en = 1'b0;
            4:  if (post) lv = !d;
            5:  en = act;
            6:  lv = 1'b0;
            7:  lv = 1'b1;
            8:  en = 1'b0;
            9:  lv = act;
            10: lv = !act;
            default: ;
        endcase
        en = en && o && !flt;
        lv = lv && en;
        return {en, lv};
    endfunction

    task automatic check(string tag, logic [1:0] exp);
        n_chk++;
        if ({drv_en, drv_level} !== exp) begin
            n_bad++;
            $display("FAIL %s: got en=%b lvl=%b expected en=%b lvl=%b",
                     tag, drv_en, drv_level, exp[1], exp[0]);
        end
    endtask

    task automatic check_fault(string tag, bit exp);
        n_chk++;
        if (fault !== exp) begin
            n_bad++;
            $display("FAIL %s: got fault=%b expected %b", tag, fault, exp);
        end
    endtask

    // Apply one vector period and check every phase cycle of it.
    task automatic run_vec(string tag, int f, bit d, bit o, int ta, int tr,
                           int len, bit flt, bit disturb);
        @(negedge clk);
        vec_start  = 1'b1;
        fmt_sel    = 4'(f);
        vec_data   = d;
        vec_is_out = o;
        t_assert   = TW'(ta);
        t_return   = TW'(tr);
        @(negedge clk);
        vec_start = 1'b0;
        if (disturb) begin
            fmt_sel    = 4'd7;
            vec_data   = !d;
            vec_is_out = !o;
            t_assert   = '0;
            t_return   = '0;
        end
        check(tag, model(f, d, o, ta, tr, 0, flt));
        for (int k = 1; k < len; k++) begin
            @(negedge clk);
            check(tag, model(f, d, o, ta, tr, k, flt));
        end
    endtask

    task automatic t_reset;
        check("R13 reset hi-z", 2'b00);
        check_fault("R9 reset", 1'b0);
    endtask

    task automatic t_nonreturn;
        run_vec("R1 nr d1", 0, 1'b1, 1'b1, 3, 7, 10, 1'b0, 1'b0);
        run_vec("R1 nr d0", 0, 1'b0, 1'b1, 3, 7, 10, 1'b0, 1'b0);
    endtask

    task automatic t_returns;
        run_vec("R2 rz", 1, 1'b1, 1'b1, 2, 5, 9, 1'b0, 1'b0);
        run_vec("R2 ro", 2, 1'b0, 1'b1, 2, 5, 9, 1'b0, 1'b0);
        run_vec("R3 rhz", 3, 1'b1, 1'b1, 1, 4, 8, 1'b0, 1'b0);
        run_vec("R4 rc d1", 4, 1'b1, 1'b1, 1, 4, 8, 1'b0, 1'b0);
        run_vec("R4 rc d0", 4, 1'b0, 1'b1, 1, 4, 8, 1'b0, 1'b0);
    endtask

    task automatic t_surround;
        run_vec("R5 surround", 5, 1'b1, 1'b1, 2, 6, 9, 1'b0, 1'b0);
        run_vec("R5 surround eq", 5, 1'b1, 1'b1, 3, 3, 6, 1'b0, 1'b0);
    endtask

    task automatic t_force;
        run_vec("R6 f0", 6, 1'b1, 1'b1, 2, 5, 7, 1'b0, 1'b0);
        run_vec("R6 f1", 7, 1'b0, 1'b1, 2, 5, 7, 1'b0, 1'b0);
        run_vec("R6 foff", 8, 1'b1, 1'b1, 2, 5, 7, 1'b0, 1'b0);
    endtask

    task automatic t_phase;
        run_vec("R7 phase", 9, 1'b0, 1'b1, 2, 5, 8, 1'b0, 1'b0);
        run_vec("R7 inv phase", 10, 1'b1, 1'b1, 2, 5, 8, 1'b0, 1'b0);
        run_vec("R7 phase from 0", 9, 1'b1, 1'b1, 0, 3, 5, 1'b0, 1'b0);
    endtask

    task automatic t_input_vec;
        run_vec("R8 input nr", 0, 1'b1, 1'b0, 2, 5, 7, 1'b0, 1'b0);
        run_vec("R8 input f1", 7, 1'b1, 1'b0, 2, 5, 7, 1'b0, 1'b0);
    endtask

    task automatic t_timing;
        run_vec("R11 saturate", 1, 1'b1, 1'b1, 2, CMAX, CMAX + 6, 1'b0, 1'b0);
        run_vec("R13 code 12", 12, 1'b1, 1'b1, 2, 4, 7, 1'b0, 1'b0);
    endtask

    task automatic t_cfg_hold;
        run_vec("R12 mid change", 3, 1'b1, 1'b1, 1, 4, 8, 1'b0, 1'b1);
        run_vec("R12 next period", 1, 1'b0, 1'b1, 1, 3, 6, 1'b0, 1'b0);
    endtask

    task automatic t_fault;
        run_vec("R10 pre fault", 0, 1'b1, 1'b1, 1, 4, 3, 1'b0, 1'b0);
        oc_event = 1'b1;
        @(negedge clk);
        oc_event = 1'b0;
        check_fault("R9 set", 1'b1);
        check("R10 hi-z after event", 2'b00);
        run_vec("R10 fault period", 7, 1'b1, 1'b1, 1, 4, 6, 1'b1, 1'b0);
        oc_event  = 1'b1;
        fault_clr = 1'b1;
        @(negedge clk);
        oc_event = 1'b0;
        check_fault("R9 event beats clear", 1'b1);
        @(negedge clk);
        fault_clr = 1'b0;
        check_fault("R9 cleared", 1'b0);
        run_vec("R10 after clear", 7, 1'b0, 1'b1, 1, 4, 6, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_nonreturn();
        t_returns();
        t_surround();
        t_force();
        t_phase();
        t_input_vec();
        t_timing();
        t_cfg_hold();
        t_fault();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule